// File: doc/BRIEF.md
# Telemetry Packet Framer with CRC-32

This block turns one sensor sample into a fixed 42-byte telemetry packet and serves it to a host over a slave SPI link. A sample has four parts: fifteen 16-bit payload words, a 32-bit timestamp and two 16-bit encoder counts. Each `sampleValid` pulse overwrites a staging image of the packet. A serial engine then computes a CRC-32 over the first 38 bytes at one byte per clock.

When the CRC is complete, the block decides whether the packet goes out. If the host's chip select is high (idle), the staged packet and its CRC are copied into a separate sending image, and `dataReady` is raised to tell the host a packet is waiting. If chip select is low, the host is still busy reading an earlier packet. In that case the sending image is left alone, the new sample is dropped and an overrun counter is incremented. The block also reports the send latency: the number of clock cycles from the capture of a sample to the end of the transfer that carried it.

Top module: `telem_framer`

## Requirements
- R1: Packet bytes 0 to 29 carry the payload. Payload word w sits at `payloadIn[16w+15:16w]`; its low byte is packet byte 2w and its high byte is packet byte 2w+1.
- R2: The timestamp occupies bytes 30 to 33, encoder 1 occupies bytes 34 and 35, and encoder 2 occupies bytes 36 and 37. Each field is least significant byte first.
- R3: Bytes 38 to 41 hold a CRC-32, least significant byte first. It is computed over bytes 0 to 37 with the reflected polynomial 0xEDB88320, a starting value of 0xFFFFFFFF and no final inversion.
- R4: The SPI link is SPI mode 1 (clock idles low). `spiMiso` changes after a rising `spiSclk` edge, `spiMosi` is sampled on the falling edge, and each byte is 8 bits, most significant bit first. Packet bytes go out in order 0 to 41 while `spiCsN` is low.
- R5: If `spiCsN` is high when the CRC finishes, the packet is loaded and `dataReady` rises within 45 clock cycles of the sample strobe. It does not rise during the 38 hashing cycles.
- R6: If `spiCsN` is low when the CRC finishes, `overrunCount` increases by exactly one. `dataReady` does not rise, and a transfer already in progress keeps sending the old packet unchanged.
- R7: A new sample that is loaded while an earlier packet is pending but not yet read replaces that packet.
- R8: `dataReady` falls once the eighth falling clock edge of byte 41 has been seen. At that moment `sendLatency` becomes the number of clock cycles from the sample strobe to that fall. `sendLatency` changes at no other time.
- R9: If `spiCsN` rises before all 42 bytes have been sent, `dataReady` falls and `sendLatency` stays unchanged.
- R10: Bytes arriving on `spiMosi` do not affect the packet that is sent. The last complete received byte appears on `hostRxByte`.
- R11: After reset, `dataReady`, `spiMiso`, `overrunCount` and `sendLatency` are all zero.
- R12: A sample strobe that arrives while the CRC is still running restarts the work. Only the newer sample is sent and no overrun is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | One-cycle strobe that captures a new sample |
| payloadIn | input | 240 | Fifteen 16-bit payload words, word 0 in the low bits |
| timestampIn | input | 32 | Capture timestamp |
| enc1In | input | 16 | Encoder 1 count |
| enc2In | input | 16 | Encoder 2 count |
| spiSclk | input | 1 | Host SPI clock |
| spiCsN | input | 1 | Host chip select, active low |
| spiMosi | input | 1 | Host-to-block serial data |
| spiMiso | output | 1 | Block-to-host serial data |
| dataReady | output | 1 | High while a loaded packet is waiting to be read or is being read |
| hostRxByte | output | 8 | Last complete byte received from the host |
| overrunCount | output | 16 | Number of samples dropped because the host was busy |
| sendLatency | output | 16 | Cycles from sample capture to the end of the last completed transfer |

## Verification
The bench sweeps several sample patterns, including all-zero and all-one fields, and compares every byte against a packet and CRC it builds itself. A field-order or byte-order error would show up as a wrong byte at a known index. A CRC with the wrong seed or a final inversion would fail even on the all-zero packet. The bench drops a sample in the middle of a transfer: a design that loaded the sending image anyway would corrupt the remaining bytes, and one that skipped the count would leave `overrunCount` flat. It also replaces a pending packet, restarts the CRC mid-hash and aborts a transfer with an early chip-select rise. These catch a stale packet, a double count, a latency that starts from the wrong sample, and a `dataReady` line that stays high after an abort.

// File: rtl/telem_framer_pkg.sv
package telem_framer_pkg;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  // strobes issued by the controller to the datapath
  typedef struct packed {
    logic capture;   // overwrite the staging image, restart CRC
    logic hashStep;  // fold one staged byte into the CRC
    logic load;      // copy staging image plus CRC into the sending image
    logic overrun;   // host busy: drop the sample
    logic finish;    // full packet clocked out
  } ctrlStrobes_t;

  // status returned by the datapath to the controller
  typedef struct packed {
    logic csHigh;        // synchronized chip select is idle
    logic csRose;        // synchronized chip select just went idle
    logic lastByteDone;  // final bit of the last packet byte sampled
  } dpStatus_t;

  function automatic logic [31:0] crcFoldByte(input logic [31:0] crcIn,
                                              input logic [7:0] dataByte);
    logic [31:0] acc;
    acc = crcIn ^ {24'd0, dataByte};
    for (int i = 0; i < 8; i++) begin
      acc = acc[0] ? ((acc >> 1) ^ CRC_POLY) : (acc >> 1);
    end
    return acc;
  endfunction

endpackage

// File: rtl/telem_framer_ctrl.sv
module telem_framer_ctrl
  import telem_framer_pkg::*;
#(
  parameter int CRC_SPAN = 38,
  parameter int HASH_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  dpStatus_t         stat,
  output ctrlStrobes_t      strb,
  output logic [HASH_W-1:0] hashIdx,
  output logic              dataReady
);

  typedef enum logic [1:0] {S_IDLE, S_HASH, S_COMMIT} ctrlState_t;

  ctrlState_t        state;
  logic [HASH_W-1:0] hashCnt;

  assign hashIdx = hashCnt;

  always_comb begin
    strb          = '0;
    strb.capture  = sampleValid;
    strb.hashStep = (state == S_HASH) && !sampleValid;
    strb.load     = (state == S_COMMIT) && !sampleValid && stat.csHigh;
    strb.overrun  = (state == S_COMMIT) && !sampleValid && !stat.csHigh;
    strb.finish   = dataReady && stat.lastByteDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      hashCnt <= '0;
    end else if (sampleValid) begin
      state   <= S_HASH;
      hashCnt <= '0;
    end else begin
      case (state)
        S_HASH: begin
          hashCnt <= hashCnt + 1'b1;
          if (hashCnt == HASH_W'(CRC_SPAN - 1)) state <= S_COMMIT;
        end
        S_COMMIT: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  // handshake line towards the host
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           dataReady <= 1'b0;
    else if (strb.load)                  dataReady <= 1'b1;
    else if (strb.finish)                dataReady <= 1'b0;
    else if (dataReady && stat.csRose)   dataReady <= 1'b0;
  end

endmodule

// File: rtl/telem_framer_dp.sv
module telem_framer_dp
  import telem_framer_pkg::*;
#(
  parameter int PAYLOAD_WORDS = 15,
  parameter int LAT_W         = 16,
  parameter int OVR_W         = 16,
  parameter int HASH_W        = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strb,
  input  logic [HASH_W-1:0]           hashIdx,
  input  logic [PAYLOAD_WORDS*16-1:0] payloadIn,
  input  logic [31:0]                 timestampIn,
  input  logic [15:0]                 enc1In,
  input  logic [15:0]                 enc2In,
  input  logic                        spiSclk,
  input  logic                        spiCsN,
  input  logic                        spiMosi,
  output dpStatus_t                   stat,
  output logic                        spiMiso,
  output logic [7:0]                  hostRxByte,
  output logic [OVR_W-1:0]            overrunCount,
  output logic [LAT_W-1:0]            sendLatency
);

  localparam int CRC_SPAN  = 2 * PAYLOAD_WORDS + 8;
  localparam int PKT_BYTES = CRC_SPAN + 4;
  localparam int IDX_W     = $clog2(PKT_BYTES + 1);

  // little-endian images: packet byte k lives at bits [8k+7:8k]
  logic [CRC_SPAN*8-1:0]  stageImg;
  logic [PKT_BYTES*8-1:0] sendImg;
  logic [31:0]            crcReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageImg <= '0;
      crcReg   <= CRC_SEED;
    end else if (strb.capture) begin
      stageImg <= {enc2In, enc1In, timestampIn, payloadIn};
      crcReg   <= CRC_SEED;
    end else if (strb.hashStep) begin
      crcReg   <= crcFoldByte(crcReg, stageImg[8*hashIdx +: 8]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          sendImg <= '0;
    else if (strb.load) sendImg <= {crcReg, stageImg};
  end

  // host-side synchronizers
  logic [2:0] sclkSync;
  logic [2:0] csSync;
  logic [1:0] mosiSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], spiSclk};
      csSync   <= {csSync[1:0], spiCsN};
      mosiSync <= {mosiSync[0], spiMosi};
    end
  end

  logic sclkRise, sclkFall;
  assign sclkRise = sclkSync[1] & ~sclkSync[2];
  assign sclkFall = ~sclkSync[1] & sclkSync[2];

  // serial shifter
  logic [2:0]       bitCnt;
  logic [IDX_W-1:0] byteIdx;
  logic [7:0]       rxShift;
  logic             misoQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      byteIdx    <= '0;
      rxShift    <= '0;
      misoQ      <= 1'b0;
      hostRxByte <= '0;
    end else if (csSync[1]) begin
      bitCnt  <= '0;
      byteIdx <= '0;
      misoQ   <= 1'b0;
    end else begin
      if (sclkRise) begin
        misoQ <= (byteIdx < IDX_W'(PKT_BYTES)) ? sendImg[{byteIdx, ~bitCnt}] : 1'b0;
      end
      if (sclkFall) begin
        rxShift <= {rxShift[6:0], mosiSync[1]};
        bitCnt  <= bitCnt + 1'b1;
        if (bitCnt == 3'd7) begin
          hostRxByte <= {rxShift[6:0], mosiSync[1]};
          if (byteIdx != IDX_W'(PKT_BYTES)) byteIdx <= byteIdx + 1'b1;
        end
      end
    end
  end

  assign spiMiso = misoQ;

  always_comb begin
    stat              = '0;
    stat.csHigh       = csSync[1];
    stat.csRose       = csSync[1] & ~csSync[2];
    stat.lastByteDone = ~csSync[1] & sclkFall & (bitCnt == 3'd7) &
                        (byteIdx == IDX_W'(PKT_BYTES - 1));
  end

  // counters
  logic [LAT_W-1:0] stageAge;
  logic [LAT_W-1:0] sendAge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrunCount <= '0;
      stageAge     <= '0;
      sendAge      <= '0;
      sendLatency  <= '0;
    end else begin
      if (strb.overrun) overrunCount <= overrunCount + 1'b1;

      if (strb.capture)        stageAge <= '0;
      else if (stageAge != '1) stageAge <= stageAge + 1'b1;

      if (strb.load)          sendAge <= (stageAge == '1) ? stageAge : stageAge + 1'b1;
      else if (sendAge != '1) sendAge <= sendAge + 1'b1;

      if (strb.finish) sendLatency <= (sendAge == '1) ? sendAge : sendAge + 1'b1;
    end
  end

endmodule

// File: rtl/telem_framer.sv
module telem_framer
  import telem_framer_pkg::*;
#(
  parameter int PAYLOAD_WORDS = 15,
  parameter int LAT_W         = 16,
  parameter int OVR_W         = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sampleValid,
  input  logic [PAYLOAD_WORDS*16-1:0] payloadIn,
  input  logic [31:0]                 timestampIn,
  input  logic [15:0]                 enc1In,
  input  logic [15:0]                 enc2In,
  input  logic                        spiSclk,
  input  logic                        spiCsN,
  input  logic                        spiMosi,
  output logic                        spiMiso,
  output logic                        dataReady,
  output logic [7:0]                  hostRxByte,
  output logic [OVR_W-1:0]            overrunCount,
  output logic [LAT_W-1:0]            sendLatency
);

  localparam int CRC_SPAN = 2 * PAYLOAD_WORDS + 8;
  localparam int HASH_W   = $clog2(CRC_SPAN);

  ctrlStrobes_t      strb;
  dpStatus_t         dpStat;
  logic [HASH_W-1:0] hashIdx;

  telem_framer_ctrl #(
    .CRC_SPAN(CRC_SPAN),
    .HASH_W  (HASH_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .stat       (dpStat),
    .strb       (strb),
    .hashIdx    (hashIdx),
    .dataReady  (dataReady)
  );

  telem_framer_dp #(
    .PAYLOAD_WORDS(PAYLOAD_WORDS),
    .LAT_W        (LAT_W),
    .OVR_W        (OVR_W),
    .HASH_W       (HASH_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .hashIdx     (hashIdx),
    .payloadIn   (payloadIn),
    .timestampIn (timestampIn),
    .enc1In      (enc1In),
    .enc2In      (enc2In),
    .spiSclk     (spiSclk),
    .spiCsN      (spiCsN),
    .spiMosi     (spiMosi),
    .stat        (dpStat),
    .spiMiso     (spiMiso),
    .hostRxByte  (hostRxByte),
    .overrunCount(overrunCount),
    .sendLatency (sendLatency)
  );

endmodule

// File: rtl/telem_framer_checker.sv
module telem_framer_checker #(
  parameter int LAT_W    = 16,
  parameter int OVR_W    = 16,
  parameter int CRC_SPAN = 38
) (
  input logic             clk,
  input logic             rstN,
  input logic             dataReady,
  input logic             csHigh,
  input logic [OVR_W-1:0] overrunCount,
  input logic [LAT_W-1:0] sendLatency
);

  // R6: a dropped sample adds exactly one to the count
  assert_overrun_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (overrunCount != $past(overrunCount)) |-> (overrunCount == $past(overrunCount) + 1'b1));

  // R6: a dropped sample never arms the handshake line
  assert_overrun_no_arm_R6: assert property (@(posedge clk) disable iff (!rstN)
    (overrunCount != $past(overrunCount)) |-> !$rose(dataReady));

  // R5: arming only happens while the host chip select is idle
  assert_arm_cs_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> $past(csHigh));

  // R8: latency is only updated when a transfer ends
  assert_latency_on_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sendLatency != $past(sendLatency)) |-> $fell(dataReady));

  // R8: a completed transfer always includes the hashing time
  assert_latency_floor_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sendLatency != $past(sendLatency)) |-> (sendLatency > LAT_W'(CRC_SPAN)));

endmodule

bind telem_framer telem_framer_checker #(
  .LAT_W   (LAT_W),
  .OVR_W   (OVR_W),
  .CRC_SPAN(CRC_SPAN)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .dataReady   (dataReady),
  .csHigh      (dpStat.csHigh),
  .overrunCount(overrunCount),
  .sendLatency (sendLatency)
);

// File: tb/telem_framer_test.sv
module telem_framer_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int NWORDS     = 15;
  localparam int NBYTES     = 42;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleValid = 1'b0;
  logic [NWORDS*16-1:0] payloadIn = '0;
  logic [31:0]       timestampIn = '0;
  logic [15:0]       enc1In = '0;
  logic [15:0]       enc2In = '0;
  logic              spiSclk = 1'b0;
  logic              spiCsN = 1'b1;
  logic              spiMosi = 1'b0;
  logic              spiMiso;
  logic              dataReady;
  logic [7:0]        hostRxByte;
  logic [15:0]       overrunCount;
  logic [15:0]       sendLatency;

  telem_framer uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .payloadIn(payloadIn),
    .timestampIn(timestampIn), .enc1In(enc1In), .enc2In(enc2In),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .dataReady(dataReady), .hostRxByte(hostRxByte),
    .overrunCount(overrunCount), .sendLatency(sendLatency)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int capCyc = 0;
  int fallCyc = 0;
  logic drPrev = 1'b0;
  logic [7:0] expPkt [NBYTES];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (drPrev && !dataReady) fallCyc = cyc;
    drPrev = dataReady;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refCrc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'd0, expPkt[i]};
      for (int b = 0; b < 8; b++) begin
        if (c[0]) c = (c >> 1) ^ 32'hEDB88320;
        else      c = c >> 1;
      end
    end
    return c;
  endfunction

  // drive one sample built from seed s; optionally rebuild expected packet
  task automatic sendSample(input int s, input bit updateExp);
    logic [15:0] w;
    logic [31:0] crc;
    @(negedge clk);
    for (int k = 0; k < NWORDS; k++) begin
      if (s == 0)      w = 16'h0000;
      else if (s == 1) w = 16'hFFFF;
      else             w = 16'(s * 4099 + k * 771) ^ 16'hA55A;
      payloadIn[16*k +: 16] = w;
      if (updateExp) begin
        expPkt[2*k]     = w[7:0];
        expPkt[2*k + 1] = w[15:8];
      end
    end
    timestampIn = (s == 0) ? 32'd0 : (s == 1) ? 32'hFFFFFFFF : 32'h1234_0000 + 32'(s * 97);
    enc1In      = (s == 0) ? 16'd0 : (s == 1) ? 16'hFFFF : 16'h8001 + 16'(s);
    enc2In      = (s == 0) ? 16'd0 : (s == 1) ? 16'hFFFF : 16'h7FFE - 16'(s * 3);
    if (updateExp) begin
      for (int b = 0; b < 4; b++) expPkt[30 + b] = timestampIn[8*b +: 8];
      expPkt[34] = enc1In[7:0];  expPkt[35] = enc1In[15:8];
      expPkt[36] = enc2In[7:0];  expPkt[37] = enc2In[15:8];
      crc = refCrc(38);
      for (int b = 0; b < 4; b++) expPkt[38 + b] = crc[8*b +: 8];
    end
    sampleValid = 1'b1;
    @(negedge clk);
    capCyc = cyc;
    sampleValid = 1'b0;
  endtask

  task automatic waitReady(input string tag);
    int n = 0;
    while (!dataReady && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(tag, {31'd0, dataReady}, 32'd1);
  endtask

  task automatic csDown();
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csUp();
    spiCsN = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  // mode 1: drive on rising, host samples just before falling
  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      spiMosi = tx[b];
      spiSclk = 1'b1;
      repeat (HALF) @(negedge clk);
      rx[b] = spiMiso;
      spiSclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic readBytes(input int first, input int last, input int mosiSeed);
    logic [7:0] rx;
    logic [7:0] tx;
    for (int k = first; k <= last; k++) begin
      tx = 8'(mosiSeed * 37 + k * 11);
      xferByte(tx, rx);
      if (k < 30)      check("R1 R4 payload byte", {24'd0, rx}, {24'd0, expPkt[k]});
      else if (k < 38) check("R2 R4 field byte", {24'd0, rx}, {24'd0, expPkt[k]});
      else             check("R3 R4 crc byte", {24'd0, rx}, {24'd0, expPkt[k]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int ovr;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 dataReady", {31'd0, dataReady}, 32'd0);
    check("R11 miso", {31'd0, spiMiso}, 32'd0);
    check("R11 overrun", {16'd0, overrunCount}, 32'd0);
    check("R11 latency", {16'd0, sendLatency}, 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // sweep of sample patterns, full reads, latency
    for (int s = 0; s < 5; s++) begin
      sendSample(s, 1'b1);
      repeat (30) @(negedge clk);
      check("R5 not armed while hashing", {31'd0, dataReady}, 32'd0);
      waitReady("R5 armed");
      csDown();
      readBytes(0, NBYTES - 1, s);
      check("R8 dataReady low after last byte", {31'd0, dataReady}, 32'd0);
      check("R8 latency", {16'd0, sendLatency}, 32'(fallCyc - capCyc));
      check("R10 host byte captured", {24'd0, hostRxByte}, {24'd0, 8'(s * 37 + 41 * 11)});
      csUp();
    end

    // R7: pending packet replaced by a newer one
    sendSample(7, 1'b0);
    waitReady("R7 first armed");
    sendSample(8, 1'b1);
    repeat (45) @(negedge clk);
    csDown();
    readBytes(0, NBYTES - 1, 3);
    check("R7 latency from newer sample", {16'd0, sendLatency}, 32'(fallCyc - capCyc));
    csUp();

    // R12: sample during hashing restarts the work
    ovr = int'(overrunCount);
    sendSample(9, 1'b0);
    repeat (10) @(negedge clk);
    sendSample(10, 1'b1);
    repeat (30) @(negedge clk);
    check("R12 restart delays arming", {31'd0, dataReady}, 32'd0);
    waitReady("R12 armed");
    check("R12 no overrun", {16'd0, overrunCount}, 32'(ovr));
    csDown();
    readBytes(0, NBYTES - 1, 5);
    csUp();

    // R6: sample while a transfer is in progress
    sendSample(11, 1'b1);
    waitReady("R6 armed");
    ovr = int'(overrunCount);
    csDown();
    readBytes(0, 4, 6);
    sendSample(12, 1'b0);
    repeat (50) @(negedge clk);
    check("R6 overrun counted", {16'd0, overrunCount}, 32'(ovr + 1));
    check("R6 still pending", {31'd0, dataReady}, 32'd1);
    readBytes(5, NBYTES - 1, 6);
    check("R6 transfer completed", {31'd0, dataReady}, 32'd0);
    csUp();

    // R6: host busy with nothing pending
    csDown();
    sendSample(13, 1'b0);
    repeat (50) @(negedge clk);
    check("R6 second overrun", {16'd0, overrunCount}, 32'(ovr + 2));
    check("R6 not armed", {31'd0, dataReady}, 32'd0);
    csUp();
    repeat (10) @(negedge clk);
    check("R6 stays unarmed after cs idle", {31'd0, dataReady}, 32'd0);

    // R9: abort part-way
    sendSample(14, 1'b1);
    waitReady("R9 armed");
    lat = int'(sendLatency);
    csDown();
    readBytes(0, 2, 7);
    csUp();
    check("R9 dataReady dropped", {31'd0, dataReady}, 32'd0);
    check("R9 latency unchanged", {16'd0, sendLatency}, 32'(lat));

    // after abort a fresh packet still goes out intact
    sendSample(15, 1'b1);
    waitReady("R9 rearmed");
    csDown();
    readBytes(0, NBYTES - 1, 8);
    check("R8 latency after abort", {16'd0, sendLatency}, 32'(fallCyc - capCyc));
    csUp();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule